// File: doc/BRIEF.md
# DDR Write-Leveling Sequencer

This block aligns each data strobe lane to the memory clock at the device. On `start` it issues a mode-register write that switches the DRAM into leveling mode. It then works through the lanes one at a time. For each lane it raises the strobe delay tap from zero in single steps. At every tap it waits for the delay line to settle and emits a one-cycle strobe request. It then waits for the DRAM's answer to arrive and reads the clock level that the DRAM sampled and returned on that lane's data line.

A level counts only after several pulses in a row at one tap have returned the same value, so flicker near the clock edge is filtered out. A lane has passed when an accepted 1 follows an accepted 0 at a lower tap. The tap where that happens is stored. A lane fails in any of three cases: the tap range runs out without that transition, the samples at one tap never settle, or the stored tap lies outside the allowed strobe-to-clock skew window. After the last lane a second mode-register write leaves leveling mode. `done` is raised only after that write and stays high until the next `start`.

Top module: `wrlvl_seq`

## Requirements
- R1: On an accepted `start`, a one-cycle `mr_wr` is emitted with `mr_sel` = 1 and `mr_data` having only bit 7 set. The first `dqs_pulse` follows exactly MR_GAP + SETTLE_CYC + 1 cycles after that write. No `dqs_pulse` occurs outside leveling mode.
- R2: `dqs_pulse` is high for a single cycle. `dly_lane` and `dly_tap` are held unchanged for at least SETTLE_CYC cycles before every pulse cycle.
- R3: The returned level is read only in the cycle that lies SAMPLE_CYC + 1 cycles after the pulse cycle. Values on `dq_fb` before that cycle have no effect.
- R4: A level is accepted only when AGREE pulses in a row at the same tap return the same value. A clean lane whose transition is at tap E (1 ≤ E ≤ max tap) uses exactly (E+1)·AGREE pulses.
- R5: The tap starts at 0 for each lane and rises by one after each accepted level. The stored tap is the first tap whose accepted level is 1 while an accepted 0 was seen at a lower tap.
- R6: If the maximum tap (all ones) is processed without a 0-to-1 transition, the lane's fail flag is set, its stored tap is 0, and the next lane starts.
- R7: If TRY_LIMIT pulses at one tap give no accepted level, the lane's fail flag is set, its stored tap is 0, and the next lane starts.
- R8: A found tap below WIN_LO or above WIN_HI is stored and also sets the lane's fail flag. A tap on either window limit passes.
- R9: Lanes are handled in ascending order 0 to LANES-1. Each lane's result is written once per run.
- R10: After the last lane, a one-cycle `mr_wr` with `mr_data` = 0 is emitted. `done` rises exactly MR_GAP + 1 cycles after that write, with no strobe pulse after it. `done` holds until the next `start`, which clears all lane results.
- R11: After reset, `done`, `dqs_pulse`, `mr_wr`, `dly_tap`, `lane_tap` and `lane_fail` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a calibration run (accepted when idle or done) |
| dq_fb | input | LANES | Clock level returned by the DRAM, one bit per lane |
| dly_lane | output | LANE_W | Lane whose strobe delay is being driven |
| dly_tap | output | TAP_W | Delay tap word for the selected lane |
| dqs_pulse | output | 1 | One-cycle strobe pulse request |
| mr_wr | output | 1 | Mode-register write strobe |
| mr_sel | output | 3 | Mode-register index for the write |
| mr_data | output | MR_DW | Mode-register write data |
| lane_tap | output | LANES*TAP_W | Stored tap per lane, lane 0 in the low bits |
| lane_fail | output | LANES | Fail flag per lane |
| done | output | 1 | Run complete, leveling mode left |

## Verification
The bench drives a stub DRAM whose returned level switches from 0 to 1 at a chosen tap per lane. It sweeps that tap over every value from 0 up to one past the top of the range, which covers the clean pass, both window limits, the skew failure, no zero ever seen, and no one ever seen. Until the exact sample cycle the stub drives the inverted level, so sampling early or late gives wrong taps. Lanes that alternate for a few pulses at the edge show that the agreement filter still finds the right tap with the right pulse count. Lanes that alternate forever show that the try limit ends the lane. Mode-register data and the delays from each write to the first pulse and to `done` are checked on every run.

// File: rtl/wrlvl_pkg.sv
// Shared definitions for the write-leveling sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package wrlvl_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MR_ON,
        ST_GAP_ON,
        ST_SETTLE,
        ST_PULSE,
        ST_WAIT,
        ST_SAMPLE,
        ST_MR_OFF,
        ST_GAP_OFF,
        ST_DONE
    } wl_state_e;

    // Largest of three wait lengths, sizes the shared wait counter.
    function automatic int wl_max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/wrlvl_agree.sv
// Agreement filter: accepts a sampled level once AGREE samples in a row
// at the current tap are equal; flags exhaustion after TRY_LIMIT samples.
// Assumes: clear is raised whenever the tap or lane changes; AGREE >= 1,
// TRY_LIMIT > AGREE.
module wrlvl_agree #(
    parameter int AGREE     = 3,
    parameter int TRY_LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic smp_en,
    input  logic smp,
    output logic accept,
    output logic level,
    output logic exhausted
);
    localparam int RUN_W = $clog2(AGREE + 1);
    localparam int TRY_W = $clog2(TRY_LIMIT + 1);

    logic             run_val;
    logic [RUN_W-1:0] run_len;
    logic [TRY_W-1:0] tries;
    logic [RUN_W-1:0] len_nxt;
    logic [TRY_W-1:0] try_nxt;

    // Next run length and try count for the sample being taken.
    always_comb begin
        len_nxt   = ((run_len != '0) && (smp == run_val)) ? run_len + 1'b1 : RUN_W'(1);
        try_nxt   = tries + 1'b1;
        accept    = smp_en && (len_nxt == RUN_W'(AGREE));
        exhausted = smp_en && !accept && (try_nxt == TRY_W'(TRY_LIMIT));
        level     = smp;
    end

    // Run and try bookkeeping; clear wins over a sample.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_val <= 1'b0;
            run_len <= '0;
            tries   <= '0;
        end else if (smp_en) begin
            run_val <= smp;
            run_len <= len_nxt;
            tries   <= try_nxt;
        end
    end

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= RUN_W'(AGREE)); // R4

endmodule

// File: rtl/wrlvl_slot.sv
// One lane's result holder: stored tap and fail flag.
// Assumes: we is raised at most once between two clr pulses.
module wrlvl_slot #(
    parameter int TAP_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [TAP_W-1:0] tap_in,
    input  logic             fail_in,
    output logic [TAP_W-1:0] tap_q,
    output logic             fail_q
);
    logic wrote;

    // Capture the lane result; cleared at the start of a run.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tap_q  <= '0;
            fail_q <= 1'b0;
            wrote  <= 1'b0;
        end else if (we) begin
            tap_q  <= tap_in;
            fail_q <= fail_in;
            wrote  <= 1'b1;
        end
    end

    AST_SLOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |-> !wrote); // R9

endmodule

// File: rtl/wrlvl_ctrl.sv
// Leveling step controller: mode-register entry/exit, per-lane tap walk,
// settle and sample waits, transition detection and window judgement.
// Assumes: SETTLE_CYC, SAMPLE_CYC, MR_GAP >= 1; accept/level/exhausted come
// from the agreement filter for the sample taken in ST_SAMPLE.
module wrlvl_ctrl
    import wrlvl_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int TAP_W      = 5,
    parameter int SETTLE_CYC = 4,
    parameter int SAMPLE_CYC = 3,
    parameter int MR_GAP     = 4,
    parameter int WIN_LO     = 2,
    parameter int WIN_HI     = 28,
    parameter int LANE_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              accept,
    input  logic              level,
    input  logic              exhausted,
    output logic              smp_en,
    output logic              clear,
    output logic              res_clr,
    output logic [TAP_W-1:0]  tap,
    output logic [LANE_W-1:0] lane,
    output logic              dqs_pulse,
    output logic              mr_wr,
    output logic              mr_lvl,
    output logic              done,
    output logic              rec_we,
    output logic [TAP_W-1:0]  rec_tap,
    output logic              rec_fail
);
    localparam int CNT_MAX = wl_max3(SETTLE_CYC, SAMPLE_CYC, MR_GAP);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [TAP_W-1:0]  TAP_END   = '1;
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);
    localparam logic [CNT_W-1:0]  SETTLE_L  = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0]  SAMPLE_L  = CNT_W'(SAMPLE_CYC - 1);
    localparam logic [CNT_W-1:0]  GAP_L     = CNT_W'(MR_GAP - 1);

    wl_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             seen0;
    logic             go, hit, give_up, step, at_end, out_win;

    // Decisions taken in the sample cycle and at run start.
    always_comb begin
        go       = start && ((state == ST_IDLE) || (state == ST_DONE));
        smp_en   = (state == ST_SAMPLE);
        at_end   = (tap == TAP_END);
        out_win  = (int'(tap) < WIN_LO) || (int'(tap) > WIN_HI);
        hit      = smp_en && accept && level && seen0;
        give_up  = smp_en && (exhausted || (accept && !hit && at_end));
        step     = smp_en && accept && !hit && !at_end;
        rec_we   = hit || give_up;
        rec_fail = give_up || (hit && out_win);
        rec_tap  = hit ? tap : '0;
        clear    = go || step || rec_we;
        res_clr  = go;
    end

    // Outputs decoded from the state register.
    always_comb begin
        dqs_pulse = (state == ST_PULSE);
        mr_wr     = (state == ST_MR_ON) || (state == ST_MR_OFF);
        mr_lvl    = (state == ST_MR_ON);
        done      = (state == ST_DONE);
    end

    // Sequencing of mode writes, waits, pulses and tap/lane stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            tap   <= '0;
            lane  <= '0;
            seen0 <= 1'b0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (go) begin
                        state <= ST_MR_ON;
                        tap   <= '0;
                        lane  <= '0;
                        seen0 <= 1'b0;
                    end
                end
                ST_MR_ON: begin
                    state <= ST_GAP_ON;
                    cnt   <= '0;
                end
                ST_GAP_ON: begin
                    if (cnt == GAP_L) begin
                        state <= ST_SETTLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (cnt == SETTLE_L) begin
                        state <= ST_PULSE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PULSE: begin
                    state <= ST_WAIT;
                    cnt   <= '0;
                end
                ST_WAIT: begin
                    if (cnt == SAMPLE_L) begin
                        state <= ST_SAMPLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_SAMPLE: begin
                    cnt <= '0;
                    if (rec_we) begin
                        if (lane == LAST_LANE) begin
                            state <= ST_MR_OFF;
                        end else begin
                            state <= ST_SETTLE;
                            lane  <= lane + 1'b1;
                            tap   <= '0;
                            seen0 <= 1'b0;
                        end
                    end else if (step) begin
                        state <= ST_SETTLE;
                        tap   <= tap + 1'b1;
                        if (!level) seen0 <= 1'b1;
                    end else begin
                        state <= ST_SETTLE;
                    end
                end
                ST_MR_OFF: begin
                    state <= ST_GAP_OFF;
                    cnt   <= '0;
                end
                ST_GAP_OFF: begin
                    if (cnt == GAP_L) begin
                        state <= ST_DONE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_pulse |=> !dqs_pulse); // R2

    AST_TAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tap) |-> ((tap == $past(tap) + 1'b1) || (tap == '0))); // R5

    AST_LANE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lane) |-> ((lane == $past(lane) + 1'b1) || (lane == '0))); // R9

    AST_NO_PULSE_AT_MR: assert property (@(posedge clk) disable iff (!rst_n)
        mr_wr |=> !dqs_pulse); // R1

endmodule

// File: rtl/wrlvl_seq.sv
// Write-leveling sequencer top: ties the step controller, the agreement
// filter and one result slot per lane, and forms the mode-register data.
// Assumes: dq_fb carries the clock level returned by the DRAM for each
// lane, valid SAMPLE_CYC+1 cycles after the strobe pulse.
module wrlvl_seq #(
    parameter int LANES      = 4,
    parameter int TAP_W      = 5,
    parameter int SETTLE_CYC = 4,
    parameter int SAMPLE_CYC = 3,
    parameter int MR_GAP     = 4,
    parameter int AGREE      = 3,
    parameter int TRY_LIMIT  = 8,
    parameter int WIN_LO     = 2,
    parameter int WIN_HI     = 28,
    parameter int MR_DW      = 16,
    parameter int MR_IDX     = 1,
    parameter int LVL_BIT    = 7,
    parameter int LANE_W     = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [LANES-1:0]       dq_fb,
    output logic [LANE_W-1:0]      dly_lane,
    output logic [TAP_W-1:0]       dly_tap,
    output logic                   dqs_pulse,
    output logic                   mr_wr,
    output logic [2:0]             mr_sel,
    output logic [MR_DW-1:0]       mr_data,
    output logic [LANES*TAP_W-1:0] lane_tap,
    output logic [LANES-1:0]       lane_fail,
    output logic                   done
);
    logic             smp_en, clear, res_clr, accept, level, exhausted;
    logic             mr_lvl, rec_we, rec_fail, smp;
    logic [TAP_W-1:0] rec_tap;
    logic             lvl_mode, exit_seen;

    wrlvl_ctrl #(
        .LANES(LANES), .TAP_W(TAP_W), .SETTLE_CYC(SETTLE_CYC),
        .SAMPLE_CYC(SAMPLE_CYC), .MR_GAP(MR_GAP),
        .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .LANE_W(LANE_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .accept(accept), .level(level), .exhausted(exhausted),
        .smp_en(smp_en), .clear(clear), .res_clr(res_clr),
        .tap(dly_tap), .lane(dly_lane), .dqs_pulse(dqs_pulse),
        .mr_wr(mr_wr), .mr_lvl(mr_lvl), .done(done),
        .rec_we(rec_we), .rec_tap(rec_tap), .rec_fail(rec_fail)
    );

    // Returned level of the lane under calibration.
    always_comb smp = dq_fb[dly_lane];

    wrlvl_agree #(.AGREE(AGREE), .TRY_LIMIT(TRY_LIMIT)) u_agree (
        .clk(clk), .rst_n(rst_n), .clear(clear), .smp_en(smp_en),
        .smp(smp), .accept(accept), .level(level), .exhausted(exhausted)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_slot
        logic [TAP_W-1:0] s_tap;
        logic             s_fail;
        wrlvl_slot #(.TAP_W(TAP_W)) u_slot (
            .clk(clk), .rst_n(rst_n), .clr(res_clr),
            .we(rec_we && (dly_lane == LANE_W'(g))),
            .tap_in(rec_tap), .fail_in(rec_fail),
            .tap_q(s_tap), .fail_q(s_fail)
        );
        assign lane_tap[g*TAP_W +: TAP_W] = s_tap;
        assign lane_fail[g]               = s_fail;
    end

    // Mode-register index and data: only the leveling bit is driven.
    always_comb begin
        mr_sel           = 3'(MR_IDX);
        mr_data          = '0;
        mr_data[LVL_BIT] = mr_lvl;
    end

    // Tracks leveling mode and the exit write, for the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_mode  <= 1'b0;
            exit_seen <= 1'b0;
        end else begin
            if (res_clr) exit_seen <= 1'b0;
            if (mr_wr && mr_lvl) lvl_mode <= 1'b1;
            if (mr_wr && !mr_lvl) begin
                lvl_mode  <= 1'b0;
                exit_seen <= 1'b1;
            end
        end
    end

    AST_PULSE_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_pulse |-> lvl_mode); // R1

    AST_DONE_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> exit_seen); // R10

endmodule

// File: tb/wrlvl_seq_test.sv
// Bench: stub DRAM with a per-lane transition tap and optional flicker,
// sweeping transition taps across the whole range.
module wrlvl_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int TAP_W      = 3;
    localparam int SETTLE_CYC = 2;
    localparam int SAMPLE_CYC = 2;
    localparam int MR_GAP     = 3;
    localparam int AGREE      = 3;
    localparam int TRY_LIMIT  = 8;
    localparam int WIN_LO     = 1;
    localparam int WIN_HI     = 6;
    localparam int MR_DW      = 16;
    localparam int LVL_BIT    = 7;
    localparam int NJ         = 4;
    localparam int MAXT       = (1 << TAP_W) - 1;
    localparam int LANE_W     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [LANES-1:0]       dq_fb = '0;
    logic [LANE_W-1:0]      dly_lane;
    logic [TAP_W-1:0]       dly_tap;
    logic                   dqs_pulse, mr_wr, done;
    logic [2:0]             mr_sel;
    logic [MR_DW-1:0]       mr_data;
    logic [LANES*TAP_W-1:0] lane_tap;
    logic [LANES-1:0]       lane_fail;

    always #(CLK_PERIOD/2) clk = ~clk;

    wrlvl_seq #(
        .LANES(LANES), .TAP_W(TAP_W), .SETTLE_CYC(SETTLE_CYC),
        .SAMPLE_CYC(SAMPLE_CYC), .MR_GAP(MR_GAP), .AGREE(AGREE),
        .TRY_LIMIT(TRY_LIMIT), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
        .MR_DW(MR_DW), .MR_IDX(1), .LVL_BIT(LVL_BIT), .LANE_W(LANE_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .dq_fb(dq_fb),
        .dly_lane(dly_lane), .dly_tap(dly_tap), .dqs_pulse(dqs_pulse),
        .mr_wr(mr_wr), .mr_sel(mr_sel), .mr_data(mr_data),
        .lane_tap(lane_tap), .lane_fail(lane_fail), .done(done)
    );

    int checks = 0;
    int failures = 0;
    int edge_pos [LANES];
    int mode [LANES];
    int pulse_cnt [LANES];
    int cyc = 0;
    int npulse = 0, stable_cyc = 0, prev_lane = -1, prev_tap = -1, cd = 0;
    logic drv_lv = 1'b0;
    logic done_q = 1'b0;
    int mr_cnt, entry_cyc, exit_cyc, first_cyc, done_cyc;
    int late_pulses, spacing_bad, order_bad, last_lane_seen;
    int entry_data, exit_data, entry_sel;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Level the stub DRAM returns for pulse n at a tap.
    function automatic logic stub_level(int ln, int tp, int n);
        if (tp == edge_pos[ln] && mode[ln] == 1) return (n < NJ) ? ((n % 2) == 1) : 1'b1;
        if (tp == edge_pos[ln] && mode[ln] == 2) return (n % 2) == 1;
        return tp >= edge_pos[ln];
    endfunction

    // Stub DRAM and port monitor, evaluated away from the active edge.
    always @(negedge clk) begin
        cyc++;
        if (int'(dly_lane) != prev_lane || int'(dly_tap) != prev_tap) begin
            prev_lane  = int'(dly_lane);
            prev_tap   = int'(dly_tap);
            npulse     = 0;
            stable_cyc = 1;
        end else begin
            stable_cyc++;
        end
        if (mr_wr) begin
            mr_cnt++;
            if (mr_data[LVL_BIT]) begin
                entry_cyc  = cyc;
                entry_data = int'(mr_data);
                entry_sel  = int'(mr_sel);
            end else begin
                exit_cyc  = cyc;
                exit_data = int'(mr_data);
            end
        end
        if (dqs_pulse) begin
            if (first_cyc < 0) first_cyc = cyc;
            if (exit_cyc >= 0) late_pulses++;
            if (stable_cyc < SETTLE_CYC + 1) spacing_bad++;
            if (int'(dly_lane) < last_lane_seen) order_bad++;
            last_lane_seen = int'(dly_lane);
            pulse_cnt[dly_lane]++;
            drv_lv = stub_level(int'(dly_lane), int'(dly_tap), npulse);
            npulse++;
            cd = SAMPLE_CYC + 1;
        end else if (cd > 0) begin
            cd--;
        end
        dq_fb = '0;
        dq_fb[dly_lane] = (cd > 0) ? ~drv_lv : drv_lv;
        if (done && !done_q) done_cyc = cyc;
        done_q = done;
    end

    task automatic run_cal(input string tag,
                           input int e0, input int m0, input int e1, input int m1,
                           input int e2, input int m2, input int e3, input int m3);
        edge_pos[0] = e0; mode[0] = m0;
        edge_pos[1] = e1; mode[1] = m1;
        edge_pos[2] = e2; mode[2] = m2;
        edge_pos[3] = e3; mode[3] = m3;
        mr_cnt = 0; entry_cyc = -1; exit_cyc = -1; first_cyc = -1; done_cyc = -1;
        late_pulses = 0; spacing_bad = 0; order_bad = 0; last_lane_seen = 0;
        entry_data = -1; exit_data = -1; entry_sel = -1;
        for (int l = 0; l < LANES; l++) pulse_cnt[l] = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        #1;
        chk($sformatf("R10 %s results cleared by start (fail)", tag), int'(lane_fail), 0);
        chk($sformatf("R10 %s results cleared by start (tap)", tag), int'(lane_tap), 0);
        for (int w = 0; w < 6000 && !done; w++) @(negedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R10 %s: actual=done low expected=done high (timeout)", tag);
        end
        @(negedge clk); #1;
        chk($sformatf("R1 %s mode writes", tag), mr_cnt, 2);
        chk($sformatf("R1 %s entry index", tag), entry_sel, 1);
        chk($sformatf("R1 %s entry data", tag), entry_data, 1 << LVL_BIT);
        chk($sformatf("R1 %s first pulse delay", tag), first_cyc - entry_cyc, MR_GAP + SETTLE_CYC + 1);
        chk($sformatf("R10 %s exit data", tag), exit_data, 0);
        chk($sformatf("R10 %s done delay", tag), done_cyc - exit_cyc, MR_GAP + 1);
        chk($sformatf("R10 %s pulses after exit", tag), late_pulses, 0);
        chk($sformatf("R2 %s short settle", tag), spacing_bad, 0);
        chk($sformatf("R9 %s lane order", tag), order_bad, 0);
        for (int l = 0; l < LANES; l++) begin
            int e, m, et, ep, ef;
            bit found;
            string rq;
            e = edge_pos[l];
            m = mode[l];
            found = (m == 0 && e >= 1 && e <= MAXT) || (m == 1);
            et = found ? e : 0;
            ef = (!found || e < WIN_LO || e > WIN_HI) ? 1 : 0;
            if (m == 0) ep = found ? (e + 1) * AGREE : (MAXT + 1) * AGREE;
            else if (m == 1) ep = e * AGREE + NJ + AGREE - 1;
            else ep = e * AGREE + TRY_LIMIT;
            if (m == 2) rq = "R7";
            else if (!found) rq = "R6";
            else if (ef == 1) rq = "R8";
            else if (m == 1) rq = "R4";
            else rq = "R3/R5";
            chk($sformatf("%s %s lane%0d tap", rq, tag, l), int'(lane_tap[l*TAP_W +: TAP_W]), et);
            chk($sformatf("%s %s lane%0d fail", rq, tag, l), int'(lane_fail[l]), ef);
            chk($sformatf("R4 %s lane%0d pulses", tag, l), pulse_cnt[l], ep);
        end
    endtask

    initial begin
        for (int l = 0; l < LANES; l++) begin
            edge_pos[l] = 0; mode[l] = 0; pulse_cnt[l] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R11 done", int'(done), 0);
        chk("R11 dqs_pulse", int'(dqs_pulse), 0);
        chk("R11 mr_wr", int'(mr_wr), 0);
        chk("R11 dly_tap", int'(dly_tap), 0);
        chk("R11 lane_tap", int'(lane_tap), 0);
        chk("R11 lane_fail", int'(lane_fail), 0);
        // Transition tap swept over 0..MAXT+1, clean lanes.
        run_cal("low",   0, 0, 1, 0, 2, 0, 3, 0);
        run_cal("high",  4, 0, 5, 0, 6, 0, 7, 0);
        run_cal("over",  8, 0, 3, 0, 5, 0, 2, 0);
        // Flicker near the edge: settles, or never settles.
        run_cal("noise", 2, 0, 3, 1, 5, 2, 6, 0);
        run_cal("mixed", 1, 1, 7, 0, 4, 0, 0, 2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule